// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block sends one control bit for every connection memory location of a time-slot switch out on a single serial line. Each frame carries one bit per location. The line runs at a multiple of the per-stream bit rate, so that all 16 streams fit into each channel period. A rate select gives 32, 64 or 128 channels per frame, which is 512, 1024 or 2048 serial bits per frame.

Within a channel period the line carries sixteen bits, one for each stream in turn. These bits belong to the next channel rather than to the current one. A device downstream therefore receives the control bit for a time slot one channel before that slot goes out on the data streams. The block reads the bits through a one-bit read port into the control-bit array. It keeps its own slot counter, which a frame sync pulse aligns.

Top module: `ctl_bit_serializer`

## Requirements
- R1: After reset, `ctl_out` is 0 until the first frame sync. It is also 0 in serial slots 0 and 1 of the first frame.
- R2: `rate_sel` 0, 1 and 2 give 32, 64 and 128 channels per frame, which is 512, 1024 and 2048 slots. Value 3 acts as 2.
- R3: The bit for stream s, channel c is held at array address s*N + c, where N is the number of channels per frame. For example, with N = 32, stream 1 channel 0 is address 32.
- R4: Serial slot p belongs to channel period p/16 and to stream p mod 16. Inside each channel period the streams go out in order 0 to 15.
- R5: Bits sent during channel period k belong to channel (k+1) mod N. The last channel period of a frame carries channel 0 of the next frame.
- R6: The read port has one clock of latency. `rd_addr` names the bit that is due two slots later, and `rd_data` must return that bit one clock after the address.
- R7: `fsync` is high during slot 0 of a frame. From slot 2 of the first frame onward, `ctl_out` in slot p equals the array bit given by R3 to R5.
- R8: Suppose a frame sync arrives while the counter is not at slot 0. That slot becomes the new slot 0. `ctl_out` is 0 in new slots 0 and 1 and then follows the new alignment.
- R9: Once aligned, the slot counter keeps wrapping at the frame length with no further sync pulses, and the output repeats every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one period per output bit |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High during the first bit slot of a frame |
| rate_sel | input | 2 | Channels per frame: 0 = 32, 1 = 64, 2 or 3 = 128 |
| rd_addr | output | 11 | Read address into the control-bit array |
| rd_data | input | 1 | Control bit returned one clock after `rd_addr` |
| ctl_out | output | 1 | Serial control bit line |

## Verification
Each bit appears on `ctl_out` in the slot it belongs to. Its address leaves two clocks earlier, and the bench memory returns the data one clock after the address. The design decides a realignment during the sync slot itself. The bench changes `fsync` just after a rising edge and reads `ctl_out` at the following falling edge. The value it reads therefore belongs to the slot that the sync (or the count from it) defines. After any rate change the bench runs one unchecked frame first, so that the two prefetched slots at the frame boundary come from the new rate.

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer #(
  parameter int STREAM_BITS  = 4,
  parameter int BASE_CH_BITS = 5,
  parameter int NUM_RATES    = 3,
  localparam int AW = STREAM_BITS + BASE_CH_BITS + NUM_RATES - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic [1:0]    rate_sel,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_data,
  output logic          ctl_out
);

  logic [AW-1:0] pos, cur, ahead, last, ch_mask;
  logic [AW-1:0] ahead_st, ahead_ch, tgt_ch;
  logic          locked, fetch_ok, bit_q, realign;
  int unsigned   ch_bits;

  always_comb begin
    ch_bits = BASE_CH_BITS +
              ((int'(rate_sel) < NUM_RATES) ? int'(rate_sel) : NUM_RATES - 1);
    ch_mask = AW'((1 << ch_bits) - 1);
    last    = AW'((1 << (ch_bits + STREAM_BITS)) - 1);
  end

  // a sync pulse is slot 0; out of step (or first) means a fresh alignment
  assign realign  = fsync && (!locked || pos != '0);
  assign cur      = fsync ? '0 : pos;

  // fetch two slots ahead: one clock of memory latency, one output register
  assign ahead    = (cur + AW'(2)) & last;
  assign ahead_st = ahead & AW'((1 << STREAM_BITS) - 1);
  assign ahead_ch = ahead >> STREAM_BITS;
  assign tgt_ch   = (ahead_ch + AW'(1)) & ch_mask;
  assign rd_addr  = (ahead_st << ch_bits) | tgt_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      locked   <= 1'b0;
      fetch_ok <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      locked   <= locked | fsync;
      fetch_ok <= locked | fsync;
      bit_q    <= fetch_ok && !realign && rd_data;
      if (locked || fsync)
        pos <= (cur >= last) ? '0 : cur + AW'(1);
      else
        pos <= '0;
    end
  end

  assign ctl_out = bit_q && !realign;

  p_quiet_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !ctl_out);

  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !fsync && pos >= last) |=> pos == '0);

  p_sync_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && last != '0) |=> pos == AW'(1));

  p_realign_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !ctl_out);

  p_free_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !fsync && pos < last && $stable(rate_sel)) |=> pos == $past(pos) + AW'(1));

endmodule

// File: tb/ctl_bit_serializer_tb.sv
module ctl_bit_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int NVEC = 10;
  // {rate_sel, slot, address that must appear alone in that slot}
  localparam int VEC [NVEC][3] = '{
    '{0, 496, 0},     // R5: last channel carries channel 0
    '{0, 497, 32},    // R3 R4: stream 1 channel 0
    '{0, 511, 480},   // R4: stream 15
    '{0, 0, 1},       // R5: channel period 0 -> channel 1
    '{0, 17, 34},     // R3 R4 R5
    '{1, 1008, 0},    // R2: 64 channels
    '{1, 1023, 960},
    '{2, 2047, 1920}, // R2: 128 channels
    '{2, 83, 390},
    '{3, 2032, 0}     // R2: value 3 acts as 128 channels
  };

  logic clk = 0, rst_n = 0, fsync = 0, rd_data = 0;
  logic [1:0] rate_sel = 0;
  logic [AW-1:0] rd_addr;
  logic ctl_out;
  logic membits [0:2047];
  int total = 0, bad = 0, cyc = 0;

  ctl_bit_serializer u_dut (.clk(clk), .rst_n(rst_n), .fsync(fsync),
    .rate_sel(rate_sel), .rd_addr(rd_addr), .rd_data(rd_data), .ctl_out(ctl_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    rd_data <= membits[rd_addr];
    cyc <= cyc + 1;
  end

  initial begin
    wait (cyc > 190000);
    bad++; total++;
    $display("FAIL watchdog: got cycle %0d exp finish", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int ref_addr(input int rate, input int p);
    int n = 32 * (rate >= 2 ? 4 : (rate == 1 ? 2 : 1));
    return (p % 16) * n + ((p / 16) + 1) % n;
  endfunction

  function automatic int frame_len(input int rate);
    return rate >= 2 ? 2048 : (rate == 1 ? 1024 : 512);
  endfunction

  task automatic run_slots(input int rate, input bit sync, input int n, input bit lead_low,
                           input bit check, input int hot, input string req);
    int errs = 0;
    for (int p = 0; p < n; p++) begin
      logic e;
      @(posedge clk); #1;
      fsync = sync && (p == 0);
      @(negedge clk);
      if (lead_low && p < 2) e = 1'b0;
      else if (hot >= 0) e = (p == hot);
      else e = membits[ref_addr(rate, p)];
      if (check && ctl_out !== e) begin
        if (errs == 0)
          $display("FAIL %s slot %0d: actual %b expected %b", req, p, ctl_out, e);
        errs++;
      end
    end
    if (check) begin
      total++;
      if (errs != 0) bad++;
    end
  endtask

  task automatic fill_pattern(input int seed);
    for (int a = 0; a < 2048; a++) membits[a] = (((a * 37 + a / 7 + seed) % 3) == 0);
  endtask

  initial begin
    for (int a = 0; a < 2048; a++) membits[a] = 1'b1;
    // R1: quiet during reset and before any sync
    begin
      int errs = 0;
      for (int i = 0; i < 12; i++) begin
        @(posedge clk); #1;
        if (i == 4) rst_n = 1;
        @(negedge clk);
        if (ctl_out !== 1'b0) errs++;
      end
      total++;
      if (errs != 0) begin
        bad++;
        $display("FAIL R1 before sync: actual %b expected 0", ctl_out);
      end
    end
    // R1 R7: first frame, slots 0 and 1 low, then data
    rate_sel = 0;
    run_slots(0, 1, 512, 1, 1, -1, "R1/R7 first frame");

    // R3 R4 R5 R6 R7: full pattern frames for each rate
    for (int r = 0; r < 3; r++) begin
      rate_sel = 2'(r);
      fill_pattern(r);
      run_slots(r, 1, frame_len(r), 0, 0, -1, "");
      run_slots(r, 1, frame_len(r), 0, 1, -1, "R3/R5/R6 pattern");
    end

    // R9: free running at 128 channels, no sync
    run_slots(2, 0, 2048, 0, 1, -1, "R9 free run");
    run_slots(2, 0, 2048, 0, 1, -1, "R9 second free frame");

    // R8: sync out of step
    run_slots(2, 0, 100, 0, 1, -1, "R8 before resync");
    run_slots(2, 1, 2048, 1, 1, -1, "R8 realigned frame");

    // R2 R3 R4 R5: one-hot vectors
    for (int v = 0; v < NVEC; v++) begin
      rate_sel = 2'(VEC[v][0]);
      for (int a = 0; a < 2048; a++) membits[a] = 1'b0;
      membits[VEC[v][2]] = 1'b1;
      run_slots(VEC[v][0], 1, frame_len(VEC[v][0]), 0, 0, -1, "");
      run_slots(VEC[v][0], 1, frame_len(VEC[v][0]), 0, 1, VEC[v][1], "R2/R3/R4/R5 vector");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule